// File: doc/BRIEF.md
# Dual-Channel Disk Host Register Bank

This block is the software-visible register file of a two-channel disk host controller. A simple byte-addressed bus reaches a 512-byte window. The bus has a write strobe, a read strobe, a 9-bit offset and 32-bit data. Write data is taken from the low end of the data word for byte-wide registers. Read data comes back one cycle after the read strobe, together with a valid flag.

Each channel holds the following registers:
- a DMA command byte;
- a 6-bit scratch byte for software;
- a DMA status byte;
- a configuration/status word;
- a 12-bit link control word;
- an interrupt-enable field.

The DMA status byte mixes three kinds of bits. Some are live inputs from the DMA engine, some are sticky event bits that software clears by writing ones, and some are plain storage. Two summary words pack both channels' command, status and interrupt state at fixed positions, so a driver can service both channels with a single read.

Each channel's interrupt input is registered into bit 11 of that channel's configuration/status word. The OR of those two bits drives the combined interrupt output. A write to a link control word with bit 0 set fires a one-cycle bus-reset pulse on that channel. Both channels also receive one such pulse right after reset.

Top module: `dual_chan_regfile`

## Requirements
- R1: The DMA command bytes read and write at 0x00 (channel 0) and 0x08 (channel 1). Writes at 0x10 and 0x18 also load them. They reset to 0.
- R2: The scratch bytes are at 0x01 (channel 0) and 0x09 (channel 1), with write-only aliases at 0x11 and 0x19. Only the low 6 bits of the data are kept, and the rest read 0.
- R3: The DMA status bytes are at 0x02 and 0x0A, with write-only aliases at 0x12 and 0x1A. They read back as follows:
  - Bit 0 reads the channel's live `dma_busy` input.
  - Bit 1 is set by a `dma_err_evt` pulse and bit 2 by a `dma_done_evt` pulse. A write with a 1 in that position clears it, and a set in the same cycle as the clear wins.
  - Bits 5 and 6 load from the write data.
  - Bits 3, 4 and 7 read 0.
- R4: The configuration/status words read at 0xA0 (channel 0) and 0xE0 (channel 1). They reset to 0x6515_0000. Bit 11 equals the channel's `ch_irq` input one cycle earlier.
- R5: `irq_out` is the OR of the two channels' bit 11, so it follows the OR of `ch_irq` one cycle later.
- R6: In the first cycle after reset is released, `ch_bus_reset` is high on both channels for exactly one cycle. It is low during reset.
- R7: The link control words are at 0x100 (channel 0) and 0x180 (channel 1) and keep data bits 11:0. A write with bit 0 set drives that channel's `ch_bus_reset` high for one cycle, starting on the cycle after the write, and leaves the other channel alone.
- R8: The interrupt-enable fields are written at 0x148 (channel 0) and 0x1C8 (channel 1). Each takes data bits 31:16 ANDed with 0x3EED and reads back in bits 31:16 at the same offset.
- R9: The link status words at 0x104 (channel 0) and 0x184 (channel 1) read 0x113 while that channel's `ch_present` is high, and 0 otherwise.
- R10: Summary word 0x10 reads as follows:
  - bits 7:0: channel 0 command, ORed with channel 0 interrupt bit 11 at bit 4 and channel 1 interrupt bit 11 at bit 6;
  - bit 14: channel 1 status bit 2;
  - bits 23:16: channel 0 status;
  - bits 31:24: channel 1 status.
- R11: Summary word 0x18 reads as follows:
  - bits 7:0: channel 1 command, ORed with channel 1 interrupt bit 11 at bit 4;
  - bits 23:16: channel 1 status;
  - all other bits 0.
- R12: Any offset not listed above reads 0, and a write to it changes no register. This includes reads of the write-only aliases and writes to 0xA0, 0xE0, 0x104 and 0x184. Every read returns its data with `bus_rvalid` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte offset into the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ch_irq | input | 2 | Per-channel interrupt input |
| ch_present | input | 2 | Per-channel drive-present input |
| dma_busy | input | 2 | Per-channel DMA active flag (status bit 0) |
| dma_err_evt | input | 2 | Per-channel pulse that sets status bit 1 |
| dma_done_evt | input | 2 | Per-channel pulse that sets status bit 2 |
| ch_bus_reset | output | 2 | Per-channel one-cycle bus-reset pulse |
| irq_out | output | 1 | Combined interrupt |

## Verification
The status byte is tested with several patterns:
- all-ones writes, which separate the loaded bits 5 and 6 from the cleared bits 1 and 2 and from the input-driven bit 0;
- a write that clears only bit 1, which shows that bit 2 is left alone;
- a clear that lands in the same cycle as a done event, which shows which side wins.

Each channel's interrupt input is raised on its own and then swapped to the other channel. This tells apart the bit-4 and bit-6 flags in the summary words and shows that the combined output covers both channels. The link control words are written both with and without bit 0, which tells a real reset pulse from a stray one and shows that the pulse reaches only the addressed channel. Writes to read-only and unmapped offsets are followed by reads of the neighbouring registers, to show that nothing was disturbed.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam logic [15:0] CFG_RESET_HI = 16'h6515;
  localparam logic [15:0] IEN_KEEP     = 16'h3EED;
  localparam logic [31:0] LINK_UP_VAL  = 32'h0000_0113;
  localparam int          CFG_IRQ_POS  = 11;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [5:0]  swd;
    logic [7:0]  stat;
    logic [31:0] cfg;
    logic [11:0] lctl;
    logic [15:0] ien;
    logic        present;
  } chan_view_t;

  // Next stored status (bit 0 left at zero; the live busy flag is merged later).
  function automatic logic [7:0] stat_next(input logic [7:0] cur,
                                           input logic [7:0] wd,
                                           input logic       we,
                                           input logic       err_set,
                                           input logic       done_set);
    logic [7:0] n;
    n = 8'h00;
    if (we) begin
      n[6:5] = wd[6:5];
      n[2:1] = cur[2:1] & ~wd[2:1];
    end else begin
      n[6:5] = cur[6:5];
      n[2:1] = cur[2:1];
    end
    n[1] = n[1] | err_set;
    n[2] = n[2] | done_set;
    return n;
  endfunction

  function automatic logic [15:0] ien_pick(input logic [31:0] wd);
    return wd[31:16] & IEN_KEEP;
  endfunction

  function automatic logic [31:0] summary_both(input chan_view_t c0,
                                               input chan_view_t c1);
    logic [31:0] r;
    r        = {24'h0, c0.cmd};
    r[4]     = r[4] | c0.cfg[CFG_IRQ_POS];
    r[6]     = r[6] | c1.cfg[CFG_IRQ_POS];
    r[14]    = c1.stat[2];
    r[23:16] = c0.stat;
    r[31:24] = c1.stat;
    return r;
  endfunction

  function automatic logic [31:0] summary_one(input chan_view_t c1);
    logic [31:0] r;
    r        = {24'h0, c1.cmd};
    r[4]     = r[4] | c1.cfg[CFG_IRQ_POS];
    r[23:16] = c1.stat;
    return r;
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        cmd_we,
  output logic [1:0]        swd_we,
  output logic [1:0]        st_we,
  output logic [1:0]        lc_we,
  output logic [1:0]        ien_we,
  output logic              rd_hit
);
  localparam int EXT_W = 16;
  logic [EXT_W-1:0] a;
  assign a = EXT_W'(addr);

  always_comb begin
    cmd_we = 2'b00;
    swd_we = 2'b00;
    st_we  = 2'b00;
    lc_we  = 2'b00;
    ien_we = 2'b00;
    case (a)
      16'h000, 16'h010: cmd_we[0] = wr;
      16'h008, 16'h018: cmd_we[1] = wr;
      16'h001, 16'h011: swd_we[0] = wr;
      16'h009, 16'h019: swd_we[1] = wr;
      16'h002, 16'h012: st_we[0]  = wr;
      16'h00A, 16'h01A: st_we[1]  = wr;
      16'h100:          lc_we[0]  = wr;
      16'h180:          lc_we[1]  = wr;
      16'h148:          ien_we[0] = wr;
      16'h1C8:          ien_we[1] = wr;
      default: ;
    endcase
  end

  always_comb begin
    case (a)
      16'h000, 16'h001, 16'h002, 16'h008, 16'h009, 16'h00A,
      16'h010, 16'h018, 16'h0A0, 16'h0E0,
      16'h100, 16'h104, 16'h148, 16'h180, 16'h184, 16'h1C8: rd_hit = 1'b1;
      default: rd_hit = 1'b0;
    endcase
  end

  // R12
  dec_single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, swd_we, st_we, lc_we, ien_we}));
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
  import dcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_we,
  input  logic              swd_we,
  input  logic              st_we,
  input  logic              lc_we,
  input  logic              ien_we,
  input  logic              irq_in,
  input  logic              present_in,
  input  logic              busy_in,
  input  logic              err_set,
  input  logic              done_set,
  output chan_view_t        view,
  output logic              bus_rst
);
  logic [7:0]  cmd_q;
  logic [5:0]  swd_q;
  logic [7:0]  st_q;
  logic        irq_q;
  logic [11:0] lctl_q;
  logic [15:0] ien_q;
  logic        boot_q;
  logic        up_q;

  // named events for the checks
  logic reset_req;
  logic done_clear_req;
  assign reset_req      = lc_we & wdata[0];
  assign done_clear_req = st_we & wdata[2];

  logic unused_wbits;
  assign unused_wbits = ^wdata[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      swd_q   <= '0;
      st_q    <= '0;
      irq_q   <= 1'b0;
      lctl_q  <= '0;
      ien_q   <= '0;
      boot_q  <= 1'b1;
      up_q    <= 1'b0;
      bus_rst <= 1'b0;
    end else begin
      if (cmd_we) cmd_q  <= wdata[7:0];
      if (swd_we) swd_q  <= wdata[5:0];
      if (lc_we)  lctl_q <= wdata[11:0];
      if (ien_we) ien_q  <= ien_pick(wdata[31:0]);
      st_q    <= stat_next(st_q, wdata[7:0], st_we, err_set, done_set);
      irq_q   <= irq_in;
      bus_rst <= boot_q | reset_req;
      boot_q  <= 1'b0;
      up_q    <= 1'b1;
    end
  end

  always_comb begin
    view.cmd     = cmd_q;
    view.swd     = swd_q;
    view.stat    = {st_q[7:1], busy_in};
    view.cfg     = {CFG_RESET_HI, 4'h0, irq_q, 11'h000};
    view.lctl    = lctl_q;
    view.ien     = ien_q;
    view.present = present_in;
  end

  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_clear_req && !done_set |=> !view.stat[2]);
  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> view.stat[2]);
  // R2
  swd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swd_we |=> $stable(view.swd));
  // R7
  lc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> bus_rst);
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> ($past(boot_q) || $past(reset_req)));
  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (view.cfg[CFG_IRQ_POS] == $past(irq_in)));
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  chan_view_t        c0,
  input  chan_view_t        c1,
  output logic [DATA_W-1:0] rdata
);
  localparam int EXT_W = 16;
  logic [EXT_W-1:0] a;
  assign a = EXT_W'(addr);

  always_comb begin
    case (a)
      16'h000: rdata = DATA_W'(c0.cmd);
      16'h001: rdata = DATA_W'(c0.swd);
      16'h002: rdata = DATA_W'(c0.stat);
      16'h008: rdata = DATA_W'(c1.cmd);
      16'h009: rdata = DATA_W'(c1.swd);
      16'h00A: rdata = DATA_W'(c1.stat);
      16'h010: rdata = DATA_W'(summary_both(c0, c1));
      16'h018: rdata = DATA_W'(summary_one(c1));
      16'h0A0: rdata = DATA_W'(c0.cfg);
      16'h0E0: rdata = DATA_W'(c1.cfg);
      16'h100: rdata = DATA_W'(c0.lctl);
      16'h104: rdata = c0.present ? DATA_W'(LINK_UP_VAL) : '0;
      16'h148: rdata = DATA_W'({c0.ien, 16'h0000});
      16'h180: rdata = DATA_W'(c1.lctl);
      16'h184: rdata = c1.present ? DATA_W'(LINK_UP_VAL) : '0;
      16'h1C8: rdata = DATA_W'({c1.ien, 16'h0000});
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_chan_regfile.sv
module dual_chan_regfile
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_CH-1:0] ch_irq,
  input  logic [NUM_CH-1:0] ch_present,
  input  logic [NUM_CH-1:0] dma_busy,
  input  logic [NUM_CH-1:0] dma_err_evt,
  input  logic [NUM_CH-1:0] dma_done_evt,
  output logic [NUM_CH-1:0] ch_bus_reset,
  output logic              irq_out
);
  logic [NUM_CH-1:0] cmd_we, swd_we, st_we, lc_we, ien_we;
  logic              rd_hit;
  chan_view_t        views [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic              up_q;

  dcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .cmd_we(cmd_we), .swd_we(swd_we), .st_we(st_we),
    .lc_we(lc_we), .ien_we(ien_we), .rd_hit(rd_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcr_chan #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
      .cmd_we(cmd_we[c]), .swd_we(swd_we[c]), .st_we(st_we[c]),
      .lc_we(lc_we[c]), .ien_we(ien_we[c]),
      .irq_in(ch_irq[c]), .present_in(ch_present[c]), .busy_in(dma_busy[c]),
      .err_set(dma_err_evt[c]), .done_set(dma_done_evt[c]),
      .view(views[c]), .bus_rst(ch_bus_reset[c])
    );
  end

  dcr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .addr(bus_addr), .c0(views[0]), .c1(views[1]), .rdata(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      up_q       <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
      up_q       <= 1'b1;
    end
  end

  always_comb begin
    irq_out = 1'b0;
    for (int c = 0; c < NUM_CH; c++) irq_out = irq_out | views[c].cfg[CFG_IRQ_POS];
  end

  // R5
  irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (irq_out == $past(|ch_irq)));
  // R12
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !rd_hit |=> (bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/sim_dual_chan_regfile.sv
`timescale 1ns/1ps
module sim_dual_chan_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  ch_irq = '0, ch_present = '0, dma_busy = '0, dma_err_evt = '0, dma_done_evt = '0;
  logic [1:0]  ch_bus_reset;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [8:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dual_chan_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_irq(ch_irq), .ch_present(ch_present),
    .dma_busy(dma_busy), .dma_err_evt(dma_err_evt), .dma_done_evt(dma_done_evt),
    .ch_bus_reset(ch_bus_reset), .irq_out(irq_out)
  );

  // monitor: pop and compare as read data arrives
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %h expected none", bus_rdata);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (bus_rdata !== x.e) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", x.tag, x.a, bus_rdata, x.e);
        end
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    x.a = a; x.e = e; x.tag = tag;
    sb.push_back(x);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic see(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, e);
    end
  endtask

  // bench's own model of the status write rule
  function automatic logic [7:0] st_model(input logic [7:0] cur, input logic [7:0] w,
                                          input logic busy);
    logic [7:0] r;
    r = {1'b0, w[6], w[5], 2'b00, (cur[2] && !w[2]), (cur[1] && !w[1]), busy};
    return r;
  endfunction

  task automatic pulse_done(input int c, input logic err);
    @(negedge clk);
    dma_done_evt[c] = 1'b1; dma_err_evt[c] = err;
    @(negedge clk);
    dma_done_evt = '0; dma_err_evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    see(32'(ch_bus_reset), 32'h0, "R6 low during reset");
    rst_n = 1'b1;
    @(negedge clk);
    see(32'(ch_bus_reset), 32'h3, "R6 pulse after reset");
    @(negedge clk);
    see(32'(ch_bus_reset), 32'h0, "R6 pulse one cycle");
    see(32'(irq_out), 32'h0, "R5 reset");

    rd(9'h0A0, 32'h6515_0000, "R4 reset ch0");
    rd(9'h0E0, 32'h6515_0000, "R4 reset ch1");
    rd(9'h000, 32'h0, "R1 reset");

    // R1
    wr(9'h000, 32'h81);
    wr(9'h018, 32'h09);
    rd(9'h000, 32'h81, "R1 ch0");
    rd(9'h008, 32'h09, "R1 ch1 via alias");
    wr(9'h010, 32'h05);
    rd(9'h000, 32'h05, "R1 ch0 via alias");

    // R2
    wr(9'h001, 32'hFF);
    rd(9'h001, 32'h3F, "R2 mask");
    wr(9'h019, 32'h2A);
    rd(9'h009, 32'h2A, "R2 alias");
    rd(9'h011, 32'h0, "R12 alias not readable");

    // R3
    dma_busy = 2'b01;
    rd(9'h002, 32'h01, "R3 busy bit");
    pulse_done(1, 1'b1);
    rd(9'h00A, 32'h06, "R3 events");
    wr(9'h01A, 32'hFF);
    rd(9'h00A, 32'(st_model(8'h06, 8'hFF, 1'b0)), "R3 all ones");
    pulse_done(1, 1'b0);
    wr(9'h00A, 32'h02);
    rd(9'h00A, 32'(st_model(8'h64, 8'h02, 1'b0)), "R3 partial clear");
    wr(9'h002, 32'hFF);
    rd(9'h002, 32'h61, "R3 ch0 all ones");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h012; bus_wdata = 32'h04; dma_done_evt[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; dma_done_evt = '0;
    rd(9'h002, 32'h05, "R3 set wins over clear");

    // R10 / R11: cmd0=05 stat0=05 cmd1=09 stat1=04
    rd(9'h010, 32'h0405_4005, "R10 summary");
    rd(9'h018, 32'h0004_0009, "R11 summary");

    // R4 / R5
    @(negedge clk); ch_irq = 2'b10;
    @(negedge clk);
    see(32'(irq_out), 32'h1, "R5 ch1 irq");
    rd(9'h0E0, 32'h6515_0800, "R4 ch1 irq bit");
    rd(9'h0A0, 32'h6515_0000, "R4 ch0 quiet");
    rd(9'h010, 32'h0405_4045, "R10 ch1 flag bit6");
    rd(9'h018, 32'h0004_0019, "R11 ch1 flag bit4");
    @(negedge clk); ch_irq = 2'b01;
    @(negedge clk);
    see(32'(irq_out), 32'h1, "R5 ch0 irq");
    rd(9'h010, 32'h0405_4015, "R10 ch0 flag bit4");
    rd(9'h018, 32'h0004_0009, "R11 no ch1 flag");
    @(negedge clk); ch_irq = 2'b00;
    @(negedge clk);
    see(32'(irq_out), 32'h0, "R5 cleared");

    // R7
    wr(9'h180, 32'hFFFF_F001);
    see(32'(ch_bus_reset), 32'h2, "R7 ch1 pulse");
    @(negedge clk);
    see(32'(ch_bus_reset), 32'h0, "R7 pulse one cycle");
    rd(9'h180, 32'h001, "R7 low 12 bits");
    wr(9'h100, 32'h0000_0ABE);
    see(32'(ch_bus_reset), 32'h0, "R7 no pulse without bit0");
    rd(9'h100, 32'hABE, "R7 ch0 store");

    // R8
    wr(9'h148, 32'hFFFF_FFFF);
    rd(9'h148, 32'h3EED_0000, "R8 ch0 mask");
    wr(9'h1C8, 32'h1234_5678);
    rd(9'h1C8, {16'h1234 & 16'h3EED, 16'h0}, "R8 ch1 mask");

    // R9
    ch_present = 2'b01;
    rd(9'h104, 32'h113, "R9 ch0 present");
    rd(9'h184, 32'h0, "R9 ch1 absent");
    ch_present = 2'b10;
    rd(9'h104, 32'h0, "R9 ch0 absent");
    rd(9'h184, 32'h113, "R9 ch1 present");

    // R12
    wr(9'h004, 32'hFFFF_FFFF);
    wr(9'h0A0, 32'hFFFF_FFFF);
    wr(9'h184, 32'hFFFF_FFFF);
    wr(9'h1FC, 32'hFFFF_FFFF);
    see(32'(ch_bus_reset), 32'h0, "R12 no pulse on ignored write");
    rd(9'h0A0, 32'h6515_0000, "R12 cfg read-only");
    rd(9'h004, 32'h0, "R12 unmapped");
    rd(9'h1FC, 32'h0, "R12 unmapped top");
    rd(9'h000, 32'h05, "R12 cmd untouched");
    rd(9'h100, 32'hABE, "R12 link ctl untouched");
    rd(9'h001, 32'h3F, "R12 scratch untouched");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12 missing read data actual %0d pending expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule